// File: doc/BRIEF.md
# Status-Framed Converter Serial Reader

This block is the host side of a three-wire serial link to a sampling converter. The converter sends a 24-bit frame. The frame starts with a ready flag, then a dummy bit, a sign bit and an extended-range bit, and ends with a 20-bit magnitude field. When a start request arrives, the reader drives chip select low and watches the data line. It waits until the converter shows that a result is ready. It then clocks the frame in and turns the two status bits into a signed 22-bit reading, with over-range and under-range flags.

The shift clock runs at a rate set by a divider input. An optional long-frame mode adds eight more clocks for hosts that expect 32-bit transfers. A limit input sets how long the reader polls. If no result arrives before that limit, the reader gives up, releases chip select and reports a timeout. It never raises chip select in the middle of a transfer.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, the shift clock is low, and the valid and timeout outputs are low.
- R2: A start pulse in idle lowers chip select. Once every half period the reader samples the data line. The shift clock stays low for as long as the sampled bit reads high.
- R3: When a poll sample reads low, the reader issues 24 shift clock pulses. Each pulse is high for clk_div_i+1 cycles and low for clk_div_i+1 cycles, so a full clock period is 2*(clk_div_i+1) cycles. The data line is sampled on each rising edge.
- R4: Chip select stays low across the whole frame. It rises in the same cycle as a one-cycle valid pulse, and that happens after the final falling edge of the shift clock.
- R5: The frame is received first bit first, in this order: bit 23 is the ready flag (0 means ready), bit 22 is a dummy bit, bit 21 is the sign, bit 20 is extended range, and bits 19 to 0 are the magnitude field, most significant bit first.
- R6: When the sign bit is 1, the reading equals the extended-range bit times 2^20 plus the field.
- R7: When the sign bit is 0, the reading equals the field minus 2^20. Field all ones therefore gives -1.
- R8: The over-range flag is set when both the sign bit and the extended-range bit are 1.
- R9: The under-range flag is set when the sign bit is 0, the extended-range bit is 1, and the reading is below -131072. A reading of exactly -131072 does not set it.
- R10: With long_frame_i high at start, 32 clock pulses are issued before chip select rises. The eight extra bits do not change the reading.
- R11: If poll_limit_i+1 polls in a row read high, chip select rises and timeout pulses for one cycle, with no valid pulse and no clock pulse.
- R12: A start pulse while a read is in progress is ignored. No second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read |
| clk_div_i | input | DIV_W | Half-period length minus one, in clk cycles |
| poll_limit_i | input | POLL_W | Allowed high polls minus one |
| long_frame_i | input | 1 | Add eight trailing clocks |
| miso_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Shift clock |
| valid_o | output | 1 | One-cycle result strobe |
| value_o | output | 22 | Signed decoded reading |
| over_o | output | 1 | Reading above reference |
| under_o | output | 1 | Reading below -1/8 full scale |
| timeout_o | output | 1 | One-cycle poll timeout strobe |
| busy_o | output | 1 | Read in progress |

## Verification
The bench models the converter. The model shifts a chosen frame out on falling clock edges and can hold its ready flag high for a set number of cycles. Each status combination is tried: in-range at full reference, clamped over-range, minus one LSB, and the two neighbours of the -1/8 boundary. Together these separate the positive and negative decode paths and the strict under-range comparison. A mixed bit pattern shows the field order. A delayed-ready read, run with a slower divider, tells polling apart from shifting and confirms the clock period. Long-frame, timeout and start-while-busy runs show that the frame length, the abort path and the start filter are correct.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    localparam int FRAME_W   = 24;
    localparam int FIELD_W   = 20;
    localparam int TAIL_W    = 8;
    localparam int OUT_W     = FIELD_W + 2;
    localparam int LONG_W    = FRAME_W + TAIL_W;
    localparam int CNT_W     = $clog2(LONG_W + 1);
    localparam int UNDER_LIM = -(1 << (FIELD_W - 3));

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;
endpackage

// File: rtl/adcrd_clkdiv.sv
module adcrd_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == div_i);
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adcrd_decode.sv
module adcrd_decode
    import adcrd_pkg::*;
(
    input  logic [FIELD_W+1:0]       bits_i,
    output logic signed [OUT_W-1:0]  value_o,
    output logic                     over_o,
    output logic                     under_o
);
    logic               sign_b, ext_b;
    logic [FIELD_W-1:0] field;

    always_comb begin
        sign_b = bits_i[FIELD_W+1];
        ext_b  = bits_i[FIELD_W];
        field  = bits_i[FIELD_W-1:0];
        if (sign_b) value_o = $signed({1'b0, ext_b, field});
        else        value_o = $signed({2'b11, field});
        over_o  = sign_b && ext_b;
        under_o = !sign_b && ext_b && (int'(value_o) < UNDER_LIM);
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int POLL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [DIV_W-1:0]        clk_div_i,
    input  logic [POLL_W-1:0]       poll_limit_i,
    input  logic                    long_frame_i,
    input  logic                    miso_i,
    output logic                    cs_n_o,
    output logic                    sclk_o,
    output logic                    valid_o,
    output logic signed [OUT_W-1:0] value_o,
    output logic                    over_o,
    output logic                    under_o,
    output logic                    timeout_o,
    output logic                    busy_o
);
    typedef struct packed {
        rd_state_e           state;
        logic                cs_n;
        logic                sclk;
        logic                long_fr;
        logic [FIELD_W+1:0]  shreg;
        logic [CNT_W-1:0]    bitcnt;
        logic [POLL_W-1:0]   pollcnt;
        logic                valid;
        logic                timeout;
        logic [OUT_W-1:0]    value;
        logic                over;
        logic                under;
    } regs_t;

    regs_t r_d, r_q;

    logic                    tick;
    logic signed [OUT_W-1:0] dec_value;
    logic                    dec_over, dec_under;
    logic [CNT_W-1:0]        frame_len;

    adcrd_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.state != ST_IDLE),
        .div_i  (clk_div_i),
        .tick_o (tick)
    );

    adcrd_decode u_dec (
        .bits_i  (r_q.shreg),
        .value_o (dec_value),
        .over_o  (dec_over),
        .under_o (dec_under)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.timeout = 1'b0;
        frame_len   = r_q.long_fr ? CNT_W'(LONG_W) : CNT_W'(FRAME_W);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_POLL;
                    r_d.cs_n    = 1'b0;
                    r_d.pollcnt = '0;
                    r_d.long_fr = long_frame_i;
                end
            end
            ST_POLL: begin
                if (tick) begin
                    if (!miso_i) begin
                        r_d.state  = ST_SHIFT;
                        r_d.bitcnt = '0;
                    end else if (r_q.pollcnt == poll_limit_i) begin
                        r_d.state   = ST_IDLE;
                        r_d.cs_n    = 1'b1;
                        r_d.timeout = 1'b1;
                    end else begin
                        r_d.pollcnt = r_q.pollcnt + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk   = 1'b1;
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                        if (r_q.bitcnt < CNT_W'(FRAME_W))
                            r_d.shreg = {r_q.shreg[FIELD_W:0], miso_i};
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.bitcnt == frame_len) begin
                            r_d.state = ST_IDLE;
                            r_d.cs_n  = 1'b1;
                            r_d.valid = 1'b1;
                            r_d.value = dec_value;
                            r_d.over  = dec_over;
                            r_d.under = dec_under;
                        end
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cs_n  = 1'b1;
                r_d.sclk  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.cs_n    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o    = r_q.cs_n;
    assign sclk_o    = r_q.sclk;
    assign valid_o   = r_q.valid;
    assign value_o   = $signed(r_q.value);
    assign over_o    = r_q.over;
    assign under_o   = r_q.under;
    assign timeout_o = r_q.timeout;
    assign busy_o    = (r_q.state != ST_IDLE);
endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker
    import adcrd_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_n_o,
    input logic                    sclk_o,
    input logic                    valid_o,
    input logic signed [OUT_W-1:0] value_o,
    input logic                    over_o,
    input logic                    under_o,
    input logic                    timeout_o
);
    // R4: clock only toggles inside a selected frame
    a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    // R4: result strobe coincides with released select
    a_r4_valid_released: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cs_n_o);
    // R4: valid is a single-cycle pulse
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R11: timeout releases select and excludes valid
    a_r11_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (cs_n_o && !valid_o));
    // R8: over flag implies a reading at or above 2^20
    a_r8_over_value: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> (int'(value_o) >= (1 << FIELD_W)));
    // R9: under flag implies a reading below the limit
    a_r9_under_value: assert property (@(posedge clk) disable iff (!rst_n)
        under_o |-> (int'(value_o) < UNDER_LIM));
endmodule

bind adc_frame_reader adcrd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .value_o   (value_o),
    .over_o    (over_o),
    .under_o   (under_o),
    .timeout_o (timeout_o)
);

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        clk_div = 8'd1;
    logic [15:0]       poll_limit = 16'd1000;
    logic              long_fr = 1'b0;
    logic              miso;
    logic              cs_n, sclk, valid, over, under, timeout, busy;
    logic signed [21:0] value;

    int checks = 0;
    int failures = 0;

    logic [23:0] frame = 24'h0;
    logic        ready = 1'b0;
    int          idx = 0;
    int          rises = 0;
    int          cyc = 0;
    int          t0 = 0;
    int          t1 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign miso = cs_n ? 1'b1 : (!ready ? 1'b1 : (idx < 24 ? frame[23 - idx] : 1'b1));

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) idx <= 0;
        else      idx <= idx + 1;
    end

    always @(negedge cs_n) rises = 0;
    always @(posedge sclk) begin
        if (rises == 0) t0 = cyc;
        if (rises == 1) t1 = cyc;
        rises = rises + 1;
    end

    adc_frame_reader dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .clk_div_i    (clk_div),
        .poll_limit_i (poll_limit),
        .long_frame_i (long_fr),
        .miso_i       (miso),
        .cs_n_o       (cs_n),
        .sclk_o       (sclk),
        .valid_o      (valid),
        .value_o      (value),
        .over_o       (over),
        .under_o      (under),
        .timeout_o    (timeout),
        .busy_o       (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (valid) begin seen = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 sclk", int'(sclk), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 timeout", int'(timeout), 0);
    endtask

    task automatic t_read(input string req, input bit sg, input bit ex, input logic [19:0] fld,
                          input bit lng, input int exp_v, input bit exp_o, input bit exp_u);
        bit seen;
        frame = {1'b0, 1'b0, sg, ex, fld};
        ready = 1'b1;
        long_fr = lng;
        pulse_start();
        wait_valid(seen);
        check({req, " valid seen"}, int'(seen), 1);
        check({req, " value"}, int'(value), exp_v);
        check({req, " over"}, int'(over), int'(exp_o));
        check({req, " under"}, int'(under), int'(exp_u));
        check("R4 cs released at valid", int'(cs_n), 1);
        check(lng ? "R10 clock count" : "R3 clock count", rises, lng ? 32 : 24);
        long_fr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_poll_delay();
        bit seen;
        clk_div = 8'd3;
        frame = {4'b0010, 20'h12345};
        ready = 1'b0;
        pulse_start();
        repeat (40) @(negedge clk);
        check("R2 cs low while polling", int'(cs_n), 0);
        check("R2 no clock while busy high", rises, 0);
        ready = 1'b1;
        wait_valid(seen);
        check("R2 result after ready", int'(value), 32'h12345);
        check("R3 clock period", t1 - t0, 8);
        clk_div = 8'd1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_timeout();
        int start_cyc;
        int got;
        bit seen = 1'b0;
        poll_limit = 16'd3;
        ready = 1'b0;
        pulse_start();
        start_cyc = cyc;
        got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (valid) seen = 1'b1;
            if (timeout) begin got = 1; break; end
        end
        check("R11 timeout raised", got, 1);
        check("R11 cs released", int'(cs_n), 1);
        check("R11 no valid", int'(seen), 0);
        check("R11 no clocks", rises, 0);
        check("R11 waited enough", int'((cyc - start_cyc) >= 8), 1);
        poll_limit = 16'd1000;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        bit seen;
        int extra = 0;
        frame = {4'b0010, 20'h00F0F};
        ready = 1'b1;
        pulse_start();
        repeat (12) @(negedge clk);
        pulse_start();
        wait_valid(seen);
        check("R12 first frame value", int'(value), 32'h00F0F);
        check("R12 clock count", rises, 24);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!cs_n || valid) extra++;
        end
        check("R12 no second frame", extra, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read("R6 full ref", 1'b1, 1'b0, 20'hFFFFF, 1'b0, 1048575, 1'b0, 1'b0);
        t_read("R8 clamp over", 1'b1, 1'b1, 20'h1FFFF, 1'b0, 1179647, 1'b1, 1'b0);
        t_read("R7 minus one", 1'b0, 1'b1, 20'hFFFFF, 1'b0, -1, 1'b0, 1'b0);
        t_read("R9 at limit", 1'b0, 1'b1, 20'hE0000, 1'b0, -131072, 1'b0, 1'b0);
        t_read("R9 below limit", 1'b0, 1'b1, 20'hDFFFF, 1'b0, -131073, 1'b0, 1'b1);
        t_read("R5 field order", 1'b1, 1'b0, 20'h5A5A5, 1'b0, 370085, 1'b0, 1'b0);
        t_read("R10 long frame", 1'b1, 1'b0, 20'h80000, 1'b1, 524288, 1'b0, 1'b0);
        t_poll_delay();
        t_timeout();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule